// File: doc/BRIEF.md
# Four-Channel Link Configuration Register Slave

This block sits on a two-wire serial control bus as a standard-mode slave and holds the settings for four high-speed signal channels. Each channel has a 4-bit equalizer code, a 2-bit flat-gain code, a 2-bit output-swing code and a power-down flag. The bus clock and data lines are sampled with the system clock, and START and STOP conditions are detected from edges of the sampled lines. A write carries an index byte that sets an internal offset, followed by data bytes. A read returns bytes from the current offset. The offset advances after every data byte, in both directions.

The slave address is the fixed prefix binary 111 followed by four address-strap inputs. A mode input chooses where the channel settings come from. In pin mode, all channels take one shared set of strap pins. In register mode, each channel takes its own register byte. A cable-absent input forces every channel into power-down in either mode.

Top module: `chcfg_i2c_top`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal {3'b111, addr_strap}. Bit 0 of the address byte selects read (1) or write (0). On a mismatch it sends no acknowledge, keeps SDA released and acknowledges no further byte until the next START.
- R2: In a write, the first byte after the address is the index. Only its low 4 bits set the offset. Each following data byte goes to the current offset, and the offset then advances by one. This continues until a STOP or a START.
- R3: A read returns the byte at the current offset, MSB first, and the offset then advances by one. When the master acknowledges (SDA low), the next byte follows. When the master does not acknowledge, the transfer ends and SDA stays released.
- R4: The offset wraps from 15 to 0, in both writes and reads.
- R5: Offset 2 holds the power-down flags. Bit 4+c is channel c (1 = powered down). Bits 3..0 are not stored and read as 0.
- R6: Offsets 3, 4, 5 and 6 hold channels 0 to 3. Bits [7:4] are the equalizer code, bits [3:2] the flat gain and bits [1:0] the swing.
- R7: Offsets 0, 1 and 7..15 always read 0, and writes to them change nothing.
- R8: Every register is 0 after rst_n. While reg_rst_n is low at a clock edge, all registers are cleared. This clear wins over a register write in the same cycle, and that byte is still acknowledged and still advances the offset.
- R9: Each accepted byte (matching address, index or data) is acknowledged by driving SDA low for the whole following clock pulse. The slave changes SDA only after SCL falls or after a START or STOP, and it never drives SCL.
- R10: A START at any point restarts the address phase. A STOP at any point returns the slave to idle with SDA released.
- R11: When mode_reg is 0, every channel's equalizer, flat-gain and swing outputs equal pin_eq, pin_fg and pin_sw.
- R12: When mode_reg is 1, channel c's equalizer, flat-gain and swing outputs come from its register byte at offset 3+c.
- R13: ch_pd bit c equals cable_absent OR the stored power-down flag of channel c, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| reg_rst_n | input | 1 | Active-low register clear, sampled on clk |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired value) |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap | input | 4 | Low four bits of the slave address |
| mode_reg | input | 1 | 1 = register mode, 0 = pin mode |
| cable_absent | input | 1 | 1 = no cable, all channels powered down |
| pin_eq | input | 4 | Equalizer strap used in pin mode |
| pin_fg | input | 2 | Flat-gain strap used in pin mode |
| pin_sw | input | 2 | Swing strap used in pin mode |
| ch_eq | output | 16 | Equalizer code, channel c at [4c+3:4c] |
| ch_fg | output | 8 | Flat-gain code, channel c at [2c+1:2c] |
| ch_sw | output | 8 | Swing code, channel c at [2c+1:2c] |
| ch_pd | output | 4 | Power-down, bit c for channel c |

## Verification
A register clear from reg_rst_n can land in the same clock edge as the write strobe of a data byte. Both the clear and the write-plus-offset-advance are then due at once. The bench provokes this by holding reg_rst_n low for the whole data byte, so the clear covers the write strobe. It then judges the result at the bus: the byte must still be acknowledged, every register must read back 0, and the next data byte must land one offset higher. Two more overlaps are covered. The offset wraps in the same cycle as a write to a reserved offset. cable_absent and a stored power-down flag are both set at once.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_DATA
  } rx_kind_t;

  // Address compare: fixed prefix concatenated with the strap bits.
  function automatic logic addr_hit(input logic [6:0] got,
                                    input logic [2:0] prefix,
                                    input logic [3:0] strap);
    return got == {prefix, strap};
  endfunction

  // Offset advance with natural wrap at the width of the pointer.
  function automatic logic [3:0] offs_next(input logic [3:0] p);
    return p + 4'd1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_scl_rise,
  output logic ev_scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC-1:0] scl_pipe;
  logic [SYNC-1:0] sda_pipe;
  logic            scl_q;
  logic            sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC-1];
      sda_q    <= sda_pipe[SYNC-1];
    end
  end

  assign scl_s       = scl_pipe[SYNC-1];
  assign sda_s       = sda_pipe[SYNC-1];
  assign ev_scl_rise = scl_s & ~scl_q;
  assign ev_scl_fall = ~scl_s & scl_q;
  assign ev_start    = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import chcfg_pkg::*;
#(
  parameter logic [2:0] ADDR_PREFIX = 3'b111,
  parameter int         IDXW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            ev_scl_rise,
  input  logic            ev_scl_fall,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic [3:0]      addr_strap,
  input  logic [7:0]      rd_data,
  output logic            sda_oe,
  output logic            wr_stb,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic [IDXW-1:0] ptr
);
  bus_st_t   st;
  rx_kind_t  kind;
  logic [7:0] sh;
  logic [7:0] tx;
  logic [3:0] cnt;
  logic       is_rd;
  logic       mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= K_ADDR;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      is_rd   <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      ptr     <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (ev_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (ev_start) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (ev_scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (ev_scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (addr_hit(sh[7:1], ADDR_PREFIX, addr_strap)) begin
                    is_rd  <= sh[0];
                    st     <= ST_RX_ACK;
                    sda_oe <= 1'b1;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_IDX: begin
                  ptr    <= sh[IDXW-1:0];
                  st     <= ST_RX_ACK;
                  sda_oe <= 1'b1;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 1'b1;
                  st      <= ST_RX_ACK;
                  sda_oe  <= 1'b1;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (ev_scl_fall) begin
              if (kind == K_ADDR && is_rd) begin
                st     <= ST_TX;
                tx     <= rd_data;
                cnt    <= '0;
                sda_oe <= ~rd_data[7];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= (kind == K_ADDR) ? K_IDX : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (ev_scl_fall) begin
              if (cnt == 4'd7) begin
                st     <= ST_TX_ACK;
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (ev_scl_rise) begin
              mack <= ~sda_s;
            end else if (ev_scl_fall) begin
              if (mack) begin
                st     <= ST_TX;
                tx     <= rd_data;
                cnt    <= '0;
                sda_oe <= ~rd_data[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/chan_regfile.sv
module chan_regfile #(
  parameter int NCH      = 4,
  parameter int IDXW     = 4,
  parameter int PD_IDX   = 2,
  parameter int CFG_BASE = 3,
  parameter int BW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_n,
  input  logic            wr_stb,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [BW-1:0]   wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [BW-1:0]   rd_data,
  output logic [NCH-1:0]  pd_bits,
  output logic [NCH*BW-1:0] cfg_bytes
);
  localparam int              PD_LSB  = BW - NCH;
  localparam logic [IDXW-1:0] PD_SLOT = IDXW'(PD_IDX);

  logic [NCH-1:0] pd_q;
  logic [BW-1:0]  cfg_q [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= '0;
    end else if (!clr_n) begin
      pd_q <= '0;
    end else if (wr_stb && wr_idx == PD_SLOT) begin
      pd_q <= wr_data[BW-1:PD_LSB];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    localparam logic [IDXW-1:0] SLOT = IDXW'(CFG_BASE + c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[c] <= '0;
      end else if (!clr_n) begin
        cfg_q[c] <= '0;
      end else if (wr_stb && wr_idx == SLOT) begin
        cfg_q[c] <= wr_data;
      end
    end
    assign cfg_bytes[c*BW +: BW] = cfg_q[c];
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == PD_SLOT) begin
      rd_data[BW-1:PD_LSB] = pd_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (rd_idx == IDXW'(CFG_BASE + c)) begin
        rd_data = cfg_q[c];
      end
    end
  end

  assign pd_bits = pd_q;
endmodule

// File: rtl/chan_cfg_mux.sv
module chan_cfg_mux #(
  parameter int NCH = 4,
  parameter int EQW = 4,
  parameter int FGW = 2,
  parameter int SWW = 2
) (
  input  logic                   mode_reg,
  input  logic                   cable_absent,
  input  logic [EQW-1:0]         pin_eq,
  input  logic [FGW-1:0]         pin_fg,
  input  logic [SWW-1:0]         pin_sw,
  input  logic [NCH-1:0]         pd_bits,
  input  logic [NCH*(EQW+FGW+SWW)-1:0] cfg_bytes,
  output logic [NCH*EQW-1:0]     ch_eq,
  output logic [NCH*FGW-1:0]     ch_fg,
  output logic [NCH*SWW-1:0]     ch_sw,
  output logic [NCH-1:0]         ch_pd
);
  localparam int BW = EQW + FGW + SWW;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BW-1:0] b;
    assign b = cfg_bytes[c*BW +: BW];
    assign ch_eq[c*EQW +: EQW] = mode_reg ? b[BW-1 -: EQW]   : pin_eq;
    assign ch_fg[c*FGW +: FGW] = mode_reg ? b[SWW +: FGW]    : pin_fg;
    assign ch_sw[c*SWW +: SWW] = mode_reg ? b[0 +: SWW]      : pin_sw;
    assign ch_pd[c]            = cable_absent | pd_bits[c];
  end
endmodule

// File: rtl/chcfg_i2c_top.sv
module chcfg_i2c_top
  import chcfg_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int EQW  = 4,
  parameter int FGW  = 2,
  parameter int SWW  = 2,
  parameter int IDXW = 4,
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [3:0]         addr_strap,
  input  logic               mode_reg,
  input  logic               cable_absent,
  input  logic [EQW-1:0]     pin_eq,
  input  logic [FGW-1:0]     pin_fg,
  input  logic [SWW-1:0]     pin_sw,
  output logic [NCH*EQW-1:0] ch_eq,
  output logic [NCH*FGW-1:0] ch_fg,
  output logic [NCH*SWW-1:0] ch_sw,
  output logic [NCH-1:0]     ch_pd
);
  localparam int BW = EQW + FGW + SWW;

  // Internal events, exposed by name for the checker.
  logic            scl_s, sda_s;
  logic            ev_scl_rise, ev_scl_fall, ev_start, ev_stop;
  logic            wr_stb;
  logic [IDXW-1:0] wr_idx;
  logic [BW-1:0]   wr_data;
  logic [IDXW-1:0] ptr;
  logic [BW-1:0]   rd_data;
  logic [NCH-1:0]  pd_bits;
  logic [NCH*BW-1:0] cfg_bytes;
  logic [NCH*BW+NCH-1:0] state_flat;
  logic            scl_unused;

  i2c_line_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s),
    .ev_scl_rise(ev_scl_rise), .ev_scl_fall(ev_scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_byte_engine #(.ADDR_PREFIX(3'b111), .IDXW(IDXW)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_scl_rise(ev_scl_rise), .ev_scl_fall(ev_scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .addr_strap(addr_strap), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .ptr(ptr)
  );

  chan_regfile #(.NCH(NCH), .IDXW(IDXW), .PD_IDX(2), .CFG_BASE(3), .BW(BW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr_n(reg_rst_n),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(ptr), .rd_data(rd_data),
    .pd_bits(pd_bits), .cfg_bytes(cfg_bytes)
  );

  chan_cfg_mux #(.NCH(NCH), .EQW(EQW), .FGW(FGW), .SWW(SWW)) u_mux (
    .mode_reg(mode_reg), .cable_absent(cable_absent),
    .pin_eq(pin_eq), .pin_fg(pin_fg), .pin_sw(pin_sw),
    .pd_bits(pd_bits), .cfg_bytes(cfg_bytes),
    .ch_eq(ch_eq), .ch_fg(ch_fg), .ch_sw(ch_sw), .ch_pd(ch_pd)
  );

  assign state_flat = {pd_bits, cfg_bytes};
  assign scl_unused = scl_s;
endmodule

// File: rtl/chcfg_i2c_chk.sv
module chcfg_i2c_chk #(
  parameter int NCH  = 4,
  parameter int EQW  = 4,
  parameter int IDXW = 4,
  parameter int SW   = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rst_n,
  input logic               sda_oe,
  input logic               ev_scl_fall,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               mode_reg,
  input logic               cable_absent,
  input logic [EQW-1:0]     pin_eq,
  input logic [NCH*EQW-1:0] ch_eq,
  input logic [NCH-1:0]     ch_pd,
  input logic               wr_stb,
  input logic [IDXW-1:0]    wr_idx,
  input logic [IDXW-1:0]    ptr,
  input logic [SW-1:0]      state_flat
);
  p_pin_eq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_reg |-> ch_eq == {NCH{pin_eq}});

  p_cable_pd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cable_absent |-> &ch_pd);

  p_sda_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(ev_scl_fall || ev_start || ev_stop));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  p_offs_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ptr == $past(wr_idx) + 1'b1);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rst_n |=> state_flat == '0);

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_rst_n && (wr_idx < 2 || wr_idx > 6)) |=> $stable(state_flat));
endmodule

bind chcfg_i2c_top chcfg_i2c_chk #(.NCH(NCH), .EQW(EQW), .IDXW(IDXW), .SW(NCH*BW+NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rst_n(reg_rst_n), .sda_oe(sda_oe),
  .ev_scl_fall(ev_scl_fall), .ev_start(ev_start), .ev_stop(ev_stop),
  .mode_reg(mode_reg), .cable_absent(cable_absent), .pin_eq(pin_eq),
  .ch_eq(ch_eq), .ch_pd(ch_pd), .wr_stb(wr_stb), .wr_idx(wr_idx),
  .ptr(ptr), .state_flat(state_flat)
);

// File: tb/tb_chcfg_i2c_top.sv
module tb_chcfg_i2c_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rst_n = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [3:0] addr_strap = 4'hA;
  logic mode_reg = 1'b1;
  logic cable_absent = 1'b0;
  logic [3:0] pin_eq = '0;
  logic [1:0] pin_fg = '0;
  logic [1:0] pin_sw = '0;
  logic [15:0] ch_eq;
  logic [7:0] ch_fg, ch_sw;
  logic [3:0] ch_pd;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mem [16];

  assign sda_bus = m_sda & ~sda_oe;
  always #4 clk = ~clk;

  chcfg_i2c_top dut (
    .clk(clk), .rst_n(rst_n), .reg_rst_n(reg_rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .addr_strap(addr_strap), .mode_reg(mode_reg),
    .cable_absent(cable_absent), .pin_eq(pin_eq), .pin_fg(pin_fg), .pin_sw(pin_sw),
    .ch_eq(ch_eq), .ch_fg(ch_fg), .ch_sw(ch_sw), .ch_pd(ch_pd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(~mack);
  endtask

  // Model of storage rules: offset 2 keeps the upper nibble, 3..6 whole byte.
  function automatic void store(input int i, input logic [7:0] v);
    if (i == 2) mem[2] = v & 8'hF0;
    else if (i >= 3 && i <= 6) mem[i] = v;
  endfunction

  function automatic logic [7:0] addr_w();
    return {3'b111, addr_strap, 1'b0};
  endfunction

  task automatic write_seq(input logic [7:0] idx, input logic [7:0] d [], input string tag);
    bit ack;
    i2c_start();
    send_byte(addr_w(), ack); chk(ack, {tag, " addr ack"}, ack, 1);
    send_byte(idx, ack);      chk(ack, {tag, " index ack R9"}, ack, 1);
    for (int k = 0; k < d.size(); k++) begin
      send_byte(d[k], ack);   chk(ack, {tag, " data ack R9"}, ack, 1);
      store((idx[3:0] + k) % 16, d[k]);
    end
    i2c_stop();
  endtask

  task automatic read_check(input logic [7:0] idx, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    i2c_start();
    send_byte(addr_w(), ack); chk(ack, {tag, " addr ack"}, ack, 1);
    send_byte(idx, ack);      chk(ack, {tag, " index ack"}, ack, 1);
    i2c_start();
    send_byte(addr_w() | 8'h01, ack); chk(ack, {tag, " read addr ack R1"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == mem[(idx[3:0] + k) % 16], {tag, " read data R3"}, b, mem[(idx[3:0] + k) % 16]);
    end
    chk(sda_oe == 1'b0, {tag, " released after NACK R3"}, sda_oe, 0);
    i2c_stop();
  endtask

  task automatic chk_outputs(input string tag);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      logic [3:0] e_eq; logic [1:0] e_fg, e_sw; logic e_pd;
      e_eq = mode_reg ? mem[3+c][7:4] : pin_eq;
      e_fg = mode_reg ? mem[3+c][3:2] : pin_fg;
      e_sw = mode_reg ? mem[3+c][1:0] : pin_sw;
      e_pd = cable_absent | mem[2][4+c];
      chk(ch_eq[4*c +: 4] == e_eq, {tag, " eq"}, ch_eq[4*c +: 4], e_eq);
      chk(ch_fg[2*c +: 2] == e_fg, {tag, " fg"}, ch_fg[2*c +: 2], e_fg);
      chk(ch_sw[2*c +: 2] == e_sw, {tag, " sw"}, ch_sw[2*c +: 2], e_sw);
      chk(ch_pd[c] == e_pd, {tag, " pd R13"}, ch_pd[c], e_pd);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d [];
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    chk(sda_oe == 1'b0, "R8 reset sda", sda_oe, 0);
    chk_outputs("R8 R12 reset outputs");

    // R1 address sweep with strap 4'hA
    for (int a = 0; a < 128; a++) begin
      bit hit;
      hit = (a == {3'b111, 4'hA});
      i2c_start();
      send_byte({a[6:0], 1'b0}, ack);
      chk(ack == hit, "R1 address match", ack, hit);
      if (!hit) begin
        send_byte(8'h00, ack);
        chk(!ack, "R1 silent after mismatch", ack, 0);
      end
      i2c_stop();
    end
    addr_strap = 4'h3;
    i2c_start(); send_byte(8'hE6, ack); chk(ack, "R1 strap 3 hit", ack, 1); i2c_stop();
    i2c_start(); send_byte(8'hF4, ack); chk(!ack, "R1 old strap miss", ack, 0); i2c_stop();

    // R2 R5 R6 R7 full write then readback
    d = new[16];
    for (int i = 0; i < 16; i++) d[i] = 8'(i * 59 + 92);
    write_seq(8'h00, d, "R2 full");
    read_check(8'h00, 16, "R5 R6 R7 full");
    chk_outputs("R12 reg mode");

    // R4 wrap: index upper bits ignored, 15 -> 0 -> 1 -> 2
    d = new[4];
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'hB7;
    write_seq(8'hFF, d, "R4 wrap write");
    read_check(8'hFE, 6, "R4 wrap read");

    // R10 STOP ends transfer: loose byte after STOP is not acknowledged
    d = new[0];
    write_seq(8'h03, d, "R10 stop");
    scl = 1'b0; wq();
    send_byte(8'h5A, ack);
    chk(!ack, "R10 no ack after stop", ack, 0);
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    // R10 START mid-byte restarts address phase
    i2c_start();
    send_byte(addr_w(), ack); send_byte(8'h04, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    i2c_start();
    send_byte(addr_w(), ack); chk(ack, "R10 restart addr", ack, 1);
    send_byte(8'h05, ack);
    send_byte(8'h6C, ack); chk(ack, "R10 restart data", ack, 1);
    store(5, 8'h6C);
    i2c_stop();
    read_check(8'h02, 6, "R10 after restart");

    // R8 register clear concurrent with a write strobe
    i2c_start();
    send_byte(addr_w(), ack); send_byte(8'h03, ack);
    reg_rst_n = 1'b0;
    send_byte(8'hC9, ack); chk(ack, "R8 ack during clear", ack, 1);
    reg_rst_n = 1'b1;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    send_byte(8'h9E, ack); chk(ack, "R8 next data ack", ack, 1);
    store(4, 8'h9E);
    i2c_stop();
    read_check(8'h00, 16, "R8 clear wins");
    chk_outputs("R8 R12 outputs after clear");

    // R11 pin-mode sweep, R13 with stored power-down flags
    d = new[1]; d[0] = 8'h50;
    write_seq(8'h02, d, "R5 pd write");
    mode_reg = 1'b0;
    for (int v = 0; v < 256; v++) begin
      pin_eq = v[7:4]; pin_fg = v[3:2]; pin_sw = v[1:0];
      cable_absent = v[0] ^ v[5];
      chk_outputs("R11 pin mode");
    end
    mode_reg = 1'b1;
    for (int cb = 0; cb < 2; cb++) begin
      cable_absent = cb[0];
      chk_outputs("R13 reg mode cable");
    end
    cable_absent = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule